// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the low-order word address for each beat of a four-word burst in a synchronous pipelined cache memory. A burst opens when the load strobe is high at a clock edge. The load strobe stands for either of the two address-status strobes. At that edge the block captures the two low external address bits as the starting word and sets its beat count to zero.

While load is low, each edge with the active-low advance input low moves the burst one beat forward. An edge with advance high holds the current word, so a controller can insert wait states. The effective address is formed from the captured start and the beat count. A mode input selects the order:

- When the mode input is high, the order is interleaved: start XOR beat.
- When the mode input is low, the order is linear: start plus beat, modulo the block size.

The mode input is not registered. A change takes effect on the current beat at once. The upper address bits, the array, the data path and write control are outside this block.

Top module: `burst_seq_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), burst_addr reads 0 until the next load.
- R2: A clock edge with load high makes burst_addr equal to the ext_addr value sampled at that edge, in either order.
- R3: With mode_il high (interleaved), the k-th beat after a load from start S reads S XOR (k mod 4); for example, start 2 gives 2, 3, 0, 1.
- R4: With mode_il low (linear), the k-th beat after a load from start S reads (S + k) mod 4; for example, start 3 gives 3, 0, 1, 2.
- R5: An edge with load low and adv_n high leaves burst_addr unchanged, provided mode_il does not change.
- R6: When load and advance (adv_n low) are both active at one edge, the load wins: burst_addr equals the new ext_addr and the beat count restarts at 0.
- R7: Advances past the fourth beat wrap within the same four-word block; the fifth beat equals the first beat.
- R8: mode_il is applied combinationally to the current beat; a change in mode re-maps burst_addr with no clock edge.
- R9: ext_addr has no effect on burst_addr at edges where load is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | AW (2) | Low external address bits, captured on load |
| load | input | 1 | Starts a burst (either address-status strobe active) |
| adv_n | input | 1 | Active-low burst advance; high suspends |
| mode_il | input | 1 | 1 = interleaved order, 0 = linear order |
| burst_addr | output | AW (2) | Effective low word address to the array |

## Verification
The following properties are checked on every cycle:

- A load returns the captured address, including when an advance arrives at the same edge.
- A suspended edge keeps the address steady.
- A linear advance adds exactly one.
- An interleaved advance always flips the low bit.

The bench scenarios are needed for the full interleaved sequence from each of the four starts. They also cover wrap-around after the fourth beat, the immediate effect of a mode change on the current beat, and the fact that the external address is ignored without a load. Each of these depends on the whole history since the load, not on a single-cycle step.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

   localparam int MAX_AW = 8;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
   parameter int AW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] ext_addr,
   output logic [AW-1:0] start_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         start_q <= '0;
      else if (load)
         start_q <= ext_addr;
   end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int AW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          adv_n,
   output logic [AW-1:0] beat_q
);
   localparam logic [AW-1:0] ONE = AW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         beat_q <= '0;
      else if (load)
         beat_q <= '0;
      else if (!adv_n)
         beat_q <= beat_q + ONE;
   end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_seq_pkg::*;
#(
   parameter int AW = 2
) (
   input  logic [AW-1:0] start_q,
   input  logic [AW-1:0] beat_q,
   input  burst_order_e  order,
   output logic [AW-1:0] addr
);
   logic [AW-1:0] il_addr;
   logic [AW-1:0] lin_addr;

   for (genvar b = 0; b < AW; b++) begin : g_il_bit
      assign il_addr[b] = start_q[b] ^ beat_q[b];
   end

   assign lin_addr = start_q + beat_q;

   always_comb begin
      if (order == ORD_INTERLEAVE)
         addr = il_addr;
      else
         addr = lin_addr;
   end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
   import burst_seq_pkg::*;
#(
   parameter int AW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ext_addr,
   input  logic          load,
   input  logic          adv_n,
   input  logic          mode_il,
   output logic [AW-1:0] burst_addr
);
   if (AW < 1 || AW > MAX_AW) begin : g_bad_aw
      $error("burst_seq_gen: AW out of range");
   end

   logic [AW-1:0] start_q;
   logic [AW-1:0] beat_q;
   burst_order_e  order;

   assign order = mode_il ? ORD_INTERLEAVE : ORD_LINEAR;

   burst_start_reg #(.AW(AW)) u_start (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .ext_addr (ext_addr),
      .start_q  (start_q)
   );

   burst_beat_ctr #(.AW(AW)) u_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .adv_n  (adv_n),
      .beat_q (beat_q)
   );

   burst_order_map #(.AW(AW)) u_map (
      .start_q (start_q),
      .beat_q  (beat_q),
      .order   (order),
      .addr    (burst_addr)
   );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
   parameter int AW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] ext_addr,
   input logic          load,
   input logic          adv_n,
   input logic          mode_il,
   input logic [AW-1:0] burst_addr
);
   logic armed;

   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(load)) |-> (burst_addr == $past(ext_addr)));

   p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(load) && !$past(adv_n)) |-> (burst_addr == $past(ext_addr)));

   p_suspend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(load) && $past(adv_n) && $stable(mode_il)) |-> $stable(burst_addr));

   p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(load) && !$past(adv_n) && !mode_il && !$past(mode_il))
      |-> (burst_addr == AW'($past(burst_addr) + AW'(1))));

   p_il_lsb_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(load) && !$past(adv_n) && mode_il && $past(mode_il))
      |-> (burst_addr[0] != $past(burst_addr[0])));
endmodule

bind burst_seq_gen burst_seq_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ext_addr   (ext_addr),
   .load       (load),
   .adv_n      (adv_n),
   .mode_il    (mode_il),
   .burst_addr (burst_addr)
);

// File: tb/test_burst_seq_gen.sv
module test_burst_seq_gen;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ext_addr = 2'd0;
   logic       load = 1'b0;
   logic       adv_n = 1'b1;
   logic       mode_il = 1'b1;
   logic [1:0] burst_addr;

   int n_cmp = 0;
   int n_bad = 0;
   int m_start = 0;
   int m_beat = 0;
   string req = "R1";
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_seq_gen #(.AW(2)) i_burst_seq_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_addr   (ext_addr),
      .load       (load),
      .adv_n      (adv_n),
      .mode_il    (mode_il),
      .burst_addr (burst_addr)
   );

   // behavioural reference: start word plus an unbounded beat number
   always @(posedge clk) begin
      if (!rst_n) begin
         m_start = 0;
         m_beat  = 0;
      end else if (load) begin
         m_start = int'(ext_addr);
         m_beat  = 0;
      end else if (!adv_n) begin
         m_beat = m_beat + 1;
      end
   end

   function automatic int expect_addr();
      if (mode_il) return m_start ^ (m_beat % 4);
      return (m_start + m_beat) % 4;
   endfunction

   task automatic compare();
      int e;
      e = expect_addr();
      n_cmp++;
      if (int'(burst_addr) !== e) begin
         n_bad++;
         $display("FAIL %s: burst_addr=%0d expected %0d (start %0d beat %0d mode %0d)",
                  req, burst_addr, e, m_start, m_beat, mode_il);
      end
   endtask

   task automatic cyc(input logic ld, input logic an, input logic [1:0] a);
      load = ld; adv_n = an; ext_addr = a;
      @(negedge clk);
      compare();
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      req = "R1";
      cyc(1'b0, 1'b1, 2'd3);   // reset value, no load yet
      cyc(1'b0, 1'b1, 2'd1);

      // both orders from every start, with a suspend and wrap past beat 4
      for (int m = 1; m >= 0; m--) begin
         mode_il = logic'(m);
         for (int s = 0; s < 4; s++) begin
            req = "R2";
            cyc(1'b1, 1'b1, 2'(s));
            req = (m == 1) ? "R3" : "R4";
            cyc(1'b0, 1'b0, 2'(3 - s));
            cyc(1'b0, 1'b0, 2'd0);
            req = "R5";
            cyc(1'b0, 1'b1, 2'd2);
            cyc(1'b0, 1'b1, 2'd1);
            req = (m == 1) ? "R3" : "R4";
            cyc(1'b0, 1'b0, 2'd0);
            req = "R7";
            cyc(1'b0, 1'b0, 2'd3);
            cyc(1'b0, 1'b0, 2'd1);
            cyc(1'b0, 1'b0, 2'd2);
         end
      end

      // load and advance together
      mode_il = 1'b1;
      req = "R6";
      cyc(1'b1, 1'b0, 2'd1);
      cyc(1'b0, 1'b0, 2'd0);
      cyc(1'b1, 1'b0, 2'd2);
      cyc(1'b0, 1'b0, 2'd0);
      mode_il = 1'b0;
      cyc(1'b1, 1'b0, 2'd3);
      cyc(1'b0, 1'b0, 2'd0);

      // mode switch on the current beat, no clock edge
      req = "R8";
      cyc(1'b1, 1'b1, 2'd2);
      cyc(1'b0, 1'b0, 2'd0);
      cyc(1'b0, 1'b0, 2'd0);   // beat 2 from start 2: linear 0
      mode_il = 1'b1; #1 compare();   // interleaved 0 as well
      cyc(1'b0, 1'b0, 2'd0);   // beat 3: interleaved 1
      mode_il = 1'b0; #1 compare();   // linear 1
      cyc(1'b0, 1'b1, 2'd0);
      mode_il = 1'b1; #1 compare();

      // external address moves without load
      req = "R9";
      cyc(1'b1, 1'b1, 2'd1);
      for (int a = 0; a < 4; a++) cyc(1'b0, 1'b1, 2'(a));
      for (int a = 0; a < 4; a++) cyc(1'b0, 1'b0, 2'(3 - a));

      // reset in the middle of a burst
      req = "R1";
      cyc(1'b1, 1'b1, 2'd3);
      rst_n = 1'b0;
      cyc(1'b0, 1'b0, 2'd2);
      rst_n = 1'b1;
      cyc(1'b0, 1'b1, 2'd2);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule